// File: doc/BRIEF.md
# E1 Remote CRC-4 and Remote Alarm Supervisor

This block watches the timeslot-0 overhead of an aligned E1 receive stream and turns the far end's reports into status. It takes one strobe per received 125 µs frame, along with the frame's position in the CRC-4 multiframe, the international (Si) bit, the remote-alarm (A) bit and a flag saying basic frame alignment is currently held. It does not compute CRC-4 itself. It only interprets the E bits that the remote end sends back.

It produces four kinds of status:
- The E1 bit captured from frame 13. It reports whether the far end saw a CRC-4 error in its first sub-multiframe.
- Two timed indications of the pattern "A set while both E bits clear":
  - one for a pattern that has lasted more than a short window (10 ms, 80 frames);
  - one for a pattern that has lasted past the short window but not yet the long window (450 ms, 3600 frames).
- A once-per-second snapshot of the E-bit error count.
- A remote failure flag. It is raised when five consecutive seconds each had more than a threshold number of E-bit errors (default 989), with no remote alarm and no loss of alignment in any of them.

All windows, the second length, the threshold and the counter width are parameters.

Top module: `e1_remote_supervisor`

## Requirements
- R1: On a frame strobe with frame number 13, the Si bit is stored and shown on `remE1Status`. No other frame changes it. 0 means the far end found a CRC-4 error and 1 means none.
- R2: The A bit is taken only on frames with an odd frame number. The first E bit is the Si bit of frame 13 and the second is the Si bit of frame 15. The watched pattern holds when the latest A is 1 and both latest E bits are 0.
- R3: `aeOver10` is 1 exactly when the pattern has held for more than T10_FRAMES consecutive frame strobes.
- R4: `aeWindow450` is 1 when the pattern has held for more than T10_FRAMES frames and fewer than T450_FRAMES frames.
- R5: From T450_FRAMES frames of the pattern onward, `aeWindow450` stays 0 until the pattern breaks. A break resets both run lengths to zero, and a new episode starts counting again.
- R6: Every E bit received as 0 in frame 13 or frame 15 adds one error. The count saturates at 2^CNT_W-1 and does not wrap.
- R7: On the last frame of each second (SEC_FRAMES frame strobes counted from reset), the error count is copied to `eSecCount` and the count restarts from zero.
- R8: A second passes when its count exceeds ERR_LIMIT, no odd frame in it carried A=1, and `alignHeld` was 1 on every one of its frames. `remFail` is 1 when the last five seconds all passed.
- R9: A failing second clears `remFail` at that second's boundary and not before.
- R10: Reset drives every output to 0 and restarts all timers and counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| frameStb | input | 1 | One pulse per received frame |
| frameNum | input | 4 | Frame number 0..15 within the CRC-4 multiframe |
| aBit | input | 1 | Remote alarm bit of the frame |
| siBit | input | 1 | Bit 1 of timeslot 0 of the frame |
| alignHeld | input | 1 | Basic frame alignment currently held |
| remE1Status | output | 1 | Last E1 bit from frame 13 |
| aeOver10 | output | 1 | Pattern held longer than the short window |
| aeWindow450 | output | 1 | Pattern held between the short and long windows |
| remFail | output | 1 | Five consecutive failing-remote seconds |
| eSecCount | output | CNT_W | E-bit error count of the last completed second |

## Verification
Every result comes from a register loaded on the clock edge that accepts a frame strobe. The value is therefore final one edge after the frame is driven, with no further pipeline. The bench drives each frame on a falling edge and checks the outputs on the falling edge after the last frame of a run, with the strobe already low. The one-second results (`eSecCount`, `remFail`) change only on the edge of a second's final frame. To check that, the bench takes samples both mid-second and right after that frame. Short test windows are used, so the threshold boundaries fall at exact frame counts.

// File: rtl/e1rs_pkg.sv
package e1rs_pkg;

  // Strobes decoded by the control for the datapath, valid for one cycle.
  typedef struct packed {
    logic frame;   // a frame is being accepted
    logic takeA;   // odd frame: A bit is meaningful
    logic takeE1;  // frame 13: Si carries first E bit
    logic takeE2;  // frame 15: Si carries second E bit
    logic secEnd;  // last frame of the current second
  } e1rsStb_t;

  localparam int E1_FRAME = 13;
  localparam int E2_FRAME = 15;

endpackage

// File: rtl/e1rs_ctrl.sv
module e1rs_ctrl
  import e1rs_pkg::*;
#(
  parameter int SEC_FRAMES = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frameStb,
  input  logic [3:0] frameNum,
  output e1rsStb_t   stb
);

  localparam int SW = $clog2(SEC_FRAMES);
  localparam logic [SW-1:0] SEC_LAST = SW'(SEC_FRAMES - 1);

  logic [SW-1:0] secCnt;
  logic          lastOfSec;

  assign lastOfSec = (secCnt == SEC_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secCnt <= '0;
    end else if (frameStb) begin
      secCnt <= lastOfSec ? '0 : secCnt + 1'b1;
    end
  end

  always_comb begin
    stb.frame  = frameStb;
    stb.takeA  = frameStb & frameNum[0];
    stb.takeE1 = frameStb & (frameNum == 4'(E1_FRAME));
    stb.takeE2 = frameStb & (frameNum == 4'(E2_FRAME));
    stb.secEnd = frameStb & lastOfSec;
  end

  // R7: the frame after a second boundary starts a fresh second
  p_sec_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.secEnd |=> (secCnt == '0));

  // R7: the second counter advances by exactly one per non-final frame
  p_sec_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.frame && !stb.secEnd) |=> (secCnt == $past(secCnt) + 1'b1));

  // R7: without a frame the second position does not move
  p_sec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStb |=> $stable(secCnt));

endmodule

// File: rtl/e1rs_datapath.sv
module e1rs_datapath
  import e1rs_pkg::*;
#(
  parameter int T10_FRAMES  = 80,
  parameter int T450_FRAMES = 3600,
  parameter int ERR_LIMIT   = 989,
  parameter int CNT_W       = 10,
  parameter int HIST_LEN    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  e1rsStb_t         stb,
  input  logic             aBit,
  input  logic             siBit,
  input  logic             alignHeld,
  output logic             remE1Status,
  output logic             aeOver10,
  output logic             aeWindow450,
  output logic             remFail,
  output logic [CNT_W-1:0] eSecCount
);

  localparam int TW = $clog2(T450_FRAMES + 1);
  localparam logic [TW-1:0]    T10_V   = TW'(T10_FRAMES);
  localparam logic [TW-1:0]    T450_V  = TW'(T450_FRAMES);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(ERR_LIMIT);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Latest overhead bits.
  logic lastA, lastE1, lastE2;
  logic aNext, e1Next, e2Next, condNow;

  // Pattern run length.
  logic [TW-1:0] runCnt;

  // Per-second accounting.
  logic [CNT_W-1:0]    errCnt;
  logic [CNT_W-1:0]    errInc;
  logic                errHit;
  logic                secClean;
  logic                secAligned;
  logic                cleanNow;
  logic                alignedNow;
  logic                secPass;
  logic [HIST_LEN-1:0] passHist;

  always_comb begin
    aNext   = stb.takeA  ? aBit  : lastA;
    e1Next  = stb.takeE1 ? siBit : lastE1;
    e2Next  = stb.takeE2 ? siBit : lastE2;
    condNow = aNext & ~e1Next & ~e2Next;

    errHit = (stb.takeE1 | stb.takeE2) & ~siBit;
    if (errHit && (errCnt != CNT_MAX)) errInc = errCnt + 1'b1;
    else                               errInc = errCnt;

    cleanNow   = secClean   & ~(stb.takeA & aBit);
    alignedNow = secAligned & ~(stb.frame & ~alignHeld);
    secPass    = (errInc > LIMIT_V) & cleanNow & alignedNow;
  end

  // Overhead bit capture.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastA       <= 1'b0;
      lastE1      <= 1'b0;
      lastE2      <= 1'b0;
      remE1Status <= 1'b0;
    end else begin
      lastA  <= aNext;
      lastE1 <= e1Next;
      lastE2 <= e2Next;
      if (stb.takeE1) remE1Status <= siBit;
    end
  end

  // Run length of the A-set/E-clear pattern, held at the long window.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      runCnt <= '0;
    end else if (stb.frame) begin
      if (!condNow)               runCnt <= '0;
      else if (runCnt != T450_V)  runCnt <= runCnt + 1'b1;
    end
  end

  assign aeOver10    = (runCnt > T10_V);
  assign aeWindow450 = aeOver10 & (runCnt < T450_V);

  // E-bit error count and per-second qualifiers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      errCnt     <= '0;
      eSecCount  <= '0;
      secClean   <= 1'b1;
      secAligned <= 1'b1;
    end else if (stb.secEnd) begin
      eSecCount  <= errInc;
      errCnt     <= '0;
      secClean   <= 1'b1;
      secAligned <= 1'b1;
    end else begin
      errCnt     <= errInc;
      secClean   <= cleanNow;
      secAligned <= alignedNow;
    end
  end

  // Pass history: one flop per remembered second.
  generate
    for (genvar g = 0; g < HIST_LEN; g++) begin : g_hist
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          passHist[g] <= 1'b0;
        end else if (stb.secEnd) begin
          if (g == 0) passHist[g] <= secPass;
          else        passHist[g] <= passHist[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  assign remFail = &passHist;

  // R1: the E1 status only moves on a frame-13 strobe
  p_e1_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb.takeE1) |-> $stable(remE1Status));

  // R5: the run length either restarts or grows by one
  p_run_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (runCnt != $past(runCnt)) |-> ((runCnt == '0) || (runCnt == $past(runCnt) + 1'b1)));

  // R6: the running count never falls except at a second boundary
  p_err_nowrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb.secEnd) |-> (errCnt >= $past(errCnt)));

  // R9: the failure flag can only change at a second boundary
  p_fail_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb.secEnd) |-> $stable(remFail));

  // R7: the published count only changes at a second boundary
  p_count_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb.secEnd) |-> $stable(eSecCount));

endmodule

// File: rtl/e1_remote_supervisor.sv
module e1_remote_supervisor
  import e1rs_pkg::*;
#(
  parameter int SEC_FRAMES  = 8000,
  parameter int T10_FRAMES  = 80,
  parameter int T450_FRAMES = 3600,
  parameter int ERR_LIMIT   = 989,
  parameter int CNT_W       = 10,
  parameter int HIST_LEN    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frameStb,
  input  logic [3:0]       frameNum,
  input  logic             aBit,
  input  logic             siBit,
  input  logic             alignHeld,
  output logic             remE1Status,
  output logic             aeOver10,
  output logic             aeWindow450,
  output logic             remFail,
  output logic [CNT_W-1:0] eSecCount
);

  e1rsStb_t stb;

  e1rs_ctrl #(
    .SEC_FRAMES(SEC_FRAMES)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .frameStb (frameStb),
    .frameNum (frameNum),
    .stb      (stb)
  );

  e1rs_datapath #(
    .T10_FRAMES (T10_FRAMES),
    .T450_FRAMES(T450_FRAMES),
    .ERR_LIMIT  (ERR_LIMIT),
    .CNT_W      (CNT_W),
    .HIST_LEN   (HIST_LEN)
  ) i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .aBit        (aBit),
    .siBit       (siBit),
    .alignHeld   (alignHeld),
    .remE1Status (remE1Status),
    .aeOver10    (aeOver10),
    .aeWindow450 (aeWindow450),
    .remFail     (remFail),
    .eSecCount   (eSecCount)
  );

endmodule

// File: tb/test_e1_remote_supervisor.sv
`timescale 1ns/1ps
module test_e1_remote_supervisor;

  localparam int SEC_F = 64;
  localparam int T10   = 8;
  localparam int T450  = 40;
  localparam int LIM   = 5;
  localparam int CW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frameStb = 1'b0;
  logic [3:0]    frameNum = '0;
  logic          aBit = 1'b0;
  logic          siBit = 1'b1;
  logic          alignHeld = 1'b1;
  logic          remE1Status, aeOver10, aeWindow450, remFail;
  logic [CW-1:0] eSecCount;

  int checks = 0;
  int failures = 0;
  int fpos = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  e1_remote_supervisor #(
    .SEC_FRAMES(SEC_F), .T10_FRAMES(T10), .T450_FRAMES(T450),
    .ERR_LIMIT(LIM), .CNT_W(CW), .HIST_LEN(5)
  ) i_e1_remote_supervisor (
    .clk(clk), .rst_n(rst_n), .frameStb(frameStb), .frameNum(frameNum),
    .aBit(aBit), .siBit(siBit), .alignHeld(alignHeld),
    .remE1Status(remE1Status), .aeOver10(aeOver10), .aeWindow450(aeWindow450),
    .remFail(remFail), .eSecCount(eSecCount)
  );

  typedef struct packed {
    logic [7:0] n;
    logic a, e1, e2, al;
    logic x10, x450, xE1;
  } vec_t;

  // Timer and E1-capture scenario; expected values after each run.
  localparam vec_t VECS [11] = '{
    '{8'd16, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R1 capture 1
    '{8'd16, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 pattern begins at frame 15
    '{8'd7,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 exactly T10 frames
    '{8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 T10+1
    '{8'd30, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R4 T450-1
    '{8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 reaches T450
    '{8'd20, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 stays low
    '{8'd1,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 break on odd frame
    '{8'd10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R5 new episode
    '{8'd1,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R2 A ignored on even frame
    '{8'd16, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}  // R2 E1 set breaks pattern
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    frameStb = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fpos = 0;
    @(negedge clk);
  endtask

  task automatic runFrames(input int n, input logic a, input logic e1,
                           input logic e2, input logic al);
    for (int i = 0; i < n; i++) begin
      frameStb  = 1'b1;
      frameNum  = 4'(fpos);
      aBit      = a;
      alignHeld = al;
      siBit     = (fpos == 13) ? e1 : (fpos == 15) ? e2 : 1'b1;
      @(negedge clk);
      fpos = (fpos + 1) % 16;
    end
    frameStb  = 1'b0;
    alignHeld = 1'b1;
  endtask

  // A second with both E bits 0: 8 errors, saturating at 7 > LIM.
  task automatic passSeconds(input int k);
    for (int s = 0; s < k; s++) runFrames(SEC_F, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    doReset();
    // R10 reset state
    check("R10 e1", remE1Status, 0);
    check("R10 over10", aeOver10, 0);
    check("R10 win450", aeWindow450, 0);
    check("R10 fail", remFail, 0);
    check("R10 count", eSecCount, 0);

    for (int v = 0; v < 11; v++) begin
      runFrames(VECS[v].n, VECS[v].a, VECS[v].e1, VECS[v].e2, VECS[v].al);
      check($sformatf("R3 over10 vec%0d", v), aeOver10, VECS[v].x10);
      check($sformatf("R4 win450 vec%0d", v), aeWindow450, VECS[v].x450);
      check($sformatf("R1 e1 vec%0d", v), remE1Status, VECS[v].xE1);
    end

    // Per-second accounting from a clean second boundary.
    doReset();
    passSeconds(1);
    check("R6 saturated count", eSecCount, 7);
    check("R8 one pass only", remFail, 0);
    passSeconds(3);
    check("R8 four passes", remFail, 0);
    passSeconds(1);
    check("R8 five passes", remFail, 1);
    runFrames(SEC_F / 2, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R9 mid-second hold", remFail, 1);
    check("R7 mid-second count", eSecCount, 7);
    runFrames(SEC_F / 2, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R9 failing second", remFail, 0);
    check("R7 count cleared", eSecCount, 0);
    runFrames(SEC_F, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R6 four errors", eSecCount, 4);
    check("R8 below limit", remFail, 0);

    passSeconds(5);
    check("R8 recovered", remFail, 1);
    runFrames(SEC_F, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R8 alarm gating", remFail, 0);
    check("R7 alarm second count", eSecCount, 7);

    passSeconds(5);
    check("R8 recovered again", remFail, 1);
    runFrames(SEC_F - 1, 1'b0, 1'b0, 1'b0, 1'b1);
    runFrames(1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 alignment gating", remFail, 0);

    passSeconds(5);
    check("R8 before reset", remFail, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 fail cleared", remFail, 0);
    check("R10 count cleared", eSecCount, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule